// File: doc/BRIEF.md
# Frame Alignment Change Recovery Controller

This block sits on the receive side of a channelized serial port that carries many HDLC channels in time slots of a TDM stream. It runs a flywheel bit counter that predicts where each frame begins and compares the receive frame-sync input against that prediction. A rising sync edge where no frame start is expected means the frame alignment has moved. Without alignment, the mapping of time slots to channels is lost for the whole group, so the block raises an alignment-error window that lasts one frame.

When the window opens, every active channel that is part-way through a message gets a one-cycle abort pulse and enters flag hunt. The deframer discards the rest of that message and waits for a new opening flag. The block then walks the channels in ascending order and requests one receive status write for each aborted channel. Each write returns buffer ownership to the host and carries the alignment-error code. When the walk is finished, it requests a single group interrupt record. Both kinds of write can be suppressed by configuration.

Top module: `cofa_recovery`

## Requirements
- R1: `bit_pos` advances by one on each cycle with `bit_en` high and wraps to 0 after the last bit of a frame. The frame is 193 bits for `line_mode` 0 (T1), 256 bits for 1 (E1), 512 bits for 2 (2xE1) and 1024 bits for 3 (4xE1). Codes 4 to 7 are unchannelized modes; they count 256-bit frames but never detect anything.
- R2: A rising edge of `rsync`, sampled on a bit where `bit_pos` is 0, is an expected sync and causes no error.
- R3: In modes 0 to 3, a rising edge of `rsync` on a bit where `bit_pos` is not 0 sets `cofa_active` at that clock edge. The same edge makes that bit the new position 0, so `bit_pos` reads 1 afterwards.
- R4: In modes 4 to 7, a rising edge of `rsync` at any position is ignored: `cofa_active` stays low and there is no abort, no status write and no interrupt.
- R5: `cofa_active` stays high for exactly one frame, meaning the frame length of the current mode counted in `bit_en` cycles from the triggering edge.
- R6: When a window opens, `ch_abort` pulses for one cycle on exactly the channels with both `ch_active` and `ch_in_msg` set, and `ch_hunt` is set for those channels. Channels that are inactive or idle are not touched.
- R7: Status requests are issued for the aborted channels in ascending channel order, skipping any channel whose `ch_inhibit` bit is set. `sts_req` and `sts_ch` stay stable until `sts_ack` is high. `sts_err` reads 4'h5 (alignment error).
- R8: After the last status request, one interrupt request is raised with `irq_err` = 4'h5 and `irq_dir` = 0 (receive). It is held until `irq_ack` is high. It is not raised when `grp_mask` is set.
- R9: A channel's `ch_hunt` bit clears only when its `flag_seen` bit is high while `cofa_active` is low. A `flag_seen` pulse during the window has no effect.
- R10: A further unexpected sync edge during an open window restarts the one-frame timer from that edge. It raises no new abort and no second interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One received line bit on this cycle |
| line_mode | input | 3 | Line mode code (see R1) |
| rsync | input | 1 | Receive frame-sync input |
| ch_active | input | NUM_CH | Channel activated |
| ch_in_msg | input | NUM_CH | Channel is inside a message |
| ch_inhibit | input | NUM_CH | Suppress status write for channel |
| grp_mask | input | 1 | Suppress group interrupt record |
| flag_seen | input | NUM_CH | Deframer found an opening flag |
| sts_ack | input | 1 | Status write accepted |
| irq_ack | input | 1 | Interrupt write accepted |
| bit_pos | output | 10 | Flywheel bit position in frame |
| cofa_active | output | 1 | Alignment-error window open |
| ch_abort | output | NUM_CH | One-cycle message abort per channel |
| ch_hunt | output | NUM_CH | Channel is hunting for an opening flag |
| sts_req | output | 1 | Status write request |
| sts_ch | output | 3 | Channel of the status write |
| sts_err | output | 4 | Error code of the status write |
| irq_req | output | 1 | Group interrupt write request |
| irq_err | output | 4 | Error code of the interrupt record |
| irq_dir | output | 1 | Direction of the interrupt record (0 = receive) |

## Verification
Some properties are checked on every cycle. These are the request/acknowledge holding of both write ports, that the interrupt never overlaps a status request, that unchannelized modes never open a window, that an abort pulse occurs only when a window opens, and that a window closes only on a bit cycle. The bench scenarios are needed for the rest. They measure the frame period of every line mode and the exact window length, including a restarted window. They check the realigned bit position, the order of status writes with inhibited and idle channels skipped, whether the interrupt appears or is masked, and the hunt release, which does not happen during the window and does happen after it.

// File: rtl/cofa_recovery.sv
module cofa_recovery #(
  parameter int NUM_CH = 8,
  parameter int T1_LEN = 193,
  parameter int E1_LEN = 256,
  parameter logic [3:0] COFA_CODE = 4'h5
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 bit_en,
  input  logic [2:0]                           line_mode,
  input  logic                                 rsync,
  input  logic [NUM_CH-1:0]                    ch_active,
  input  logic [NUM_CH-1:0]                    ch_in_msg,
  input  logic [NUM_CH-1:0]                    ch_inhibit,
  input  logic                                 grp_mask,
  input  logic [NUM_CH-1:0]                    flag_seen,
  input  logic                                 sts_ack,
  input  logic                                 irq_ack,
  output logic [$clog2(4*E1_LEN)-1:0]          bit_pos,
  output logic                                 cofa_active,
  output logic [NUM_CH-1:0]                    ch_abort,
  output logic [NUM_CH-1:0]                    ch_hunt,
  output logic                                 sts_req,
  output logic [(NUM_CH>1?$clog2(NUM_CH):1)-1:0] sts_ch,
  output logic [3:0]                           sts_err,
  output logic                                 irq_req,
  output logic [3:0]                           irq_err,
  output logic                                 irq_dir
);
  localparam int MAX_LEN = 4 * E1_LEN;
  localparam int POS_W   = $clog2(MAX_LEN);
  localparam int WIN_W   = POS_W + 1;
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  typedef enum logic [1:0] {S_IDLE, S_SCAN, S_IRQ} st_t;

  st_t               state;
  logic              rsync_q;
  logic [WIN_W-1:0]  frame_len;
  logic [WIN_W-1:0]  win_left;
  logic [NUM_CH-1:0] wr_pend;
  logic [CH_W-1:0]   scan_ptr;

  wire chan_mode = (line_mode <= 3'd3);
  wire rise      = bit_en & rsync & ~rsync_q;
  wire trig      = rise & chan_mode & (bit_pos != '0);
  wire new_win   = trig & ~cofa_active;
  wire wrap      = ({1'b0, bit_pos} >= frame_len - WIN_W'(1));
  wire [NUM_CH-1:0] hit = ch_active & ch_in_msg;
  wire need      = wr_pend[scan_ptr];
  wire last      = (scan_ptr == CH_W'(NUM_CH - 1));
  wire advance   = (state == S_SCAN) & (~need | sts_ack);

  always_comb begin
    case (line_mode)
      3'd0:    frame_len = WIN_W'(T1_LEN);
      3'd2:    frame_len = WIN_W'(2 * E1_LEN);
      3'd3:    frame_len = WIN_W'(4 * E1_LEN);
      default: frame_len = WIN_W'(E1_LEN);
    endcase
  end

  assign sts_req = (state == S_SCAN) & need;
  assign sts_ch  = scan_ptr;
  assign sts_err = sts_req ? COFA_CODE : 4'h0;
  assign irq_req = (state == S_IRQ);
  assign irq_err = irq_req ? COFA_CODE : 4'h0;
  assign irq_dir = 1'b0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsync_q <= 1'b0;
      bit_pos <= '0;
    end else if (bit_en) begin
      rsync_q <= rsync;
      if (trig)      bit_pos <= POS_W'(1);
      else if (wrap) bit_pos <= '0;
      else           bit_pos <= bit_pos + POS_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cofa_active <= 1'b0;
      win_left    <= '0;
    end else if (trig) begin
      cofa_active <= 1'b1;
      win_left    <= frame_len;
    end else if (bit_en && cofa_active) begin
      if (win_left == WIN_W'(1)) cofa_active <= 1'b0;
      win_left <= win_left - WIN_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch_abort <= '0;
      ch_hunt  <= '0;
    end else begin
      ch_abort <= new_win ? hit : '0;
      ch_hunt  <= (ch_hunt & ~(flag_seen & {NUM_CH{~cofa_active}})) | (new_win ? hit : '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wr_pend  <= '0;
      scan_ptr <= '0;
    end else if (new_win) begin
      state    <= S_SCAN;
      wr_pend  <= wr_pend | (hit & ~ch_inhibit);
      scan_ptr <= '0;
    end else begin
      case (state)
        S_SCAN: if (advance) begin
          wr_pend[scan_ptr] <= 1'b0;
          if (last) state <= grp_mask ? S_IDLE : S_IRQ;
          else      scan_ptr <= scan_ptr + CH_W'(1);
        end
        S_IRQ:  if (irq_ack) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R7
  sts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sts_req && !sts_ack |=> sts_req && $stable(sts_ch));
  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req);
  // R8
  irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> !sts_req);
  // R4
  unchan_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_mode && !cofa_active |=> !cofa_active);
  // R6
  abort_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_abort != '0) |-> $rose(cofa_active));
  // R5
  win_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cofa_active) |-> $past(bit_en));
endmodule

// File: tb/cofa_recovery_tb_top.sv
module cofa_recovery_tb_top;
  localparam int NCH = 8;
  localparam int IRQ_ITEM = 100;
  localparam int STALL = 2;

  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, rsync = 1'b0, grp_mask = 1'b0;
  logic [2:0] line_mode = 3'd0;
  logic [NCH-1:0] ch_active = '0, ch_in_msg = '0, ch_inhibit = '0, flag_seen = '0;
  logic sts_ack = 1'b0, irq_ack = 1'b0;
  logic [9:0] bit_pos;
  logic cofa_active, sts_req, irq_req, irq_dir;
  logic [NCH-1:0] ch_abort, ch_hunt;
  logic [2:0] sts_ch;
  logic [3:0] sts_err, irq_err;

  int checks = 0, errors = 0, sts_wait = 0, irq_wait = 0;
  int exp_q[$];
  bit done = 0;

  always #5 clk = ~clk;

  cofa_recovery dut_i (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .line_mode(line_mode), .rsync(rsync),
    .ch_active(ch_active), .ch_in_msg(ch_in_msg), .ch_inhibit(ch_inhibit),
    .grp_mask(grp_mask), .flag_seen(flag_seen), .sts_ack(sts_ack), .irq_ack(irq_ack),
    .bit_pos(bit_pos), .cofa_active(cofa_active), .ch_abort(ch_abort), .ch_hunt(ch_hunt),
    .sts_req(sts_req), .sts_ch(sts_ch), .sts_err(sts_err), .irq_req(irq_req),
    .irq_err(irq_err), .irq_dir(irq_dir));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic take_item(input int item, input string req);
    int front;
    if (exp_q.size() == 0) begin
      chk(0, req, item, -1);
    end else begin
      front = exp_q.pop_front();
      chk(front == item, req, item, front);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      sts_ack = 0; irq_ack = 0; sts_wait = 0; irq_wait = 0;
    end else begin
      if (sts_req) begin
        if (sts_wait == STALL) begin
          take_item(int'(sts_ch), "R7 status order");
          chk(sts_err == 4'h5, "R7 status code", int'(sts_err), 5);
          sts_ack = 1; sts_wait = 0;
        end else begin
          sts_ack = 0; sts_wait++;
        end
      end else begin
        sts_ack = 0; sts_wait = 0;
      end
      if (irq_req) begin
        if (irq_wait == STALL) begin
          take_item(IRQ_ITEM, "R8 interrupt order");
          chk(irq_err == 4'h5 && irq_dir == 1'b0, "R8 interrupt fields",
              int'({irq_dir, irq_err}), 5);
          irq_ack = 1; irq_wait = 0;
        end else begin
          irq_ack = 0; irq_wait++;
        end
      end else begin
        irq_ack = 0; irq_wait = 0;
      end
    end
  end

  task automatic wait_pos(input int p);
    int n = 0;
    while (int'(bit_pos) != p && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic start_cofa(input logic [NCH-1:0] act, input logic [NCH-1:0] msg,
                            input logic [NCH-1:0] inh, input bit msk, input int p);
    wait_pos(p);
    ch_active = act; ch_in_msg = msg; ch_inhibit = inh; grp_mask = msk;
    if (!cofa_active && line_mode <= 3'd3) begin
      for (int i = 0; i < NCH; i++)
        if (act[i] && msg[i] && !inh[i]) exp_q.push_back(i);
      if (!msk) exp_q.push_back(IRQ_ITEM);
    end
    rsync = 1;
    @(negedge clk);
    rsync = 0;
  endtask

  task automatic measure_period(input int exp, input string req);
    int n = 1;
    wait_pos(0);
    @(negedge clk);
    while (bit_pos != 0 && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
  endtask

  task automatic measure_win(input int already, input int exp, input string req);
    int n = already;
    while (cofa_active && n < 5000) begin n++; @(negedge clk); end
    chk(n == exp, req, n, exp);
  endtask

  task automatic clear_hunt();
    flag_seen = '1; @(negedge clk); flag_seen = '0; @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(bit_pos == 0 && !cofa_active, "reset pos/window", int'(bit_pos), 0);
    chk(!sts_req && !irq_req && ch_hunt == 0 && ch_abort == 0, "reset requests",
        int'({sts_req, irq_req}), 0);
    bit_en = 1;

    // R1 frame periods per mode
    measure_period(193, "R1 T1 period");
    line_mode = 3'd1; measure_period(256, "R1 E1 period");
    line_mode = 3'd2; measure_period(512, "R1 2xE1 period");
    line_mode = 3'd3; measure_period(1024, "R1 4xE1 period");
    line_mode = 3'd0; measure_period(193, "R1 T1 after switch");

    // R2 expected sync
    ch_active = '1; ch_in_msg = '1;
    wait_pos(0); rsync = 1; @(negedge clk); rsync = 0;
    chk(!cofa_active && ch_abort == 0, "R2 expected sync", int'(cofa_active), 0);
    chk(bit_pos == 1, "R2 position continues", int'(bit_pos), 1);

    // R4 unchannelized mode ignores sync
    line_mode = 3'd5;
    start_cofa('1, '1, '0, 0, 50);
    chk(!cofa_active && ch_abort == 0 && ch_hunt == 0, "R4 ignored in mode 5",
        int'(cofa_active), 0);
    repeat (30) @(negedge clk);
    chk(!cofa_active && exp_q.size() == 0, "R4 no writes", exp_q.size(), 0);

    // main T1 event
    line_mode = 3'd0;
    start_cofa(8'b1011_0110, 8'b1111_0011, 8'b0001_0000, 0, 50);
    chk(cofa_active == 1, "R3 window opens", int'(cofa_active), 1);
    chk(bit_pos == 1, "R3 realigned position", int'(bit_pos), 1);
    chk(ch_abort == 8'hB2, "R6 abort mask", int'(ch_abort), 'hB2);
    chk(ch_hunt == 8'hB2, "R6 hunt mask", int'(ch_hunt), 'hB2);
    flag_seen = 8'h02;
    @(negedge clk);
    flag_seen = '0;
    chk(ch_abort == 0, "R6 abort is one cycle", int'(ch_abort), 0);
    @(negedge clk);
    chk(ch_hunt == 8'hB2, "R9 flag ignored in window", int'(ch_hunt), 'hB2);
    measure_win(2, 193, "R5 T1 window length");
    chk(exp_q.size() == 0, "R8 all writes then interrupt", exp_q.size(), 0);
    flag_seen = 8'h02; @(negedge clk); flag_seen = '0; @(negedge clk);
    chk(ch_hunt == 8'hB0, "R9 flag releases hunt", int'(ch_hunt), 'hB0);

    // masked interrupt, E1 window
    clear_hunt();
    line_mode = 3'd1;
    start_cofa('1, 8'h0F, '0, 1, 77);
    chk(ch_abort == 8'h0F, "R6 idle channels skipped", int'(ch_abort), 'h0F);
    @(negedge clk);
    measure_win(1, 256, "R5 E1 window length");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && !irq_req, "R8 masked interrupt", exp_q.size(), 0);

    // R10 retrigger
    clear_hunt();
    line_mode = 3'd0;
    start_cofa(8'h3C, '1, '0, 0, 20);
    start_cofa(8'h3C, '1, '0, 0, 41);
    chk(ch_abort == 0 && cofa_active, "R10 no second abort", int'(ch_abort), 0);
    @(negedge clk);
    measure_win(1, 193, "R10 timer restarted");
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R10 single interrupt", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule